// File: doc/BRIEF.md
# Jam-Loaded Reference and Feedback Divider Pair

This block holds the two programmable down-counters that sit in front of a digital phase/frequency detector in a frequency synthesizer. A reference divider advances on every cycle in which the oscillator count enable is high. A feedback divider advances on every cycle in which the VCO count enable is high. Each divider emits a one-clock pulse when its count runs out, then reloads itself from its ratio register. Both dividers and the detector run from a single fast clock. The two enables stand in for the real input clocks.

Writing a new feedback ratio does three things in the same clock. It reloads both counters at once, it drops any pulse that was about to be issued, and it clears the detector flags. Lock acquisition therefore starts from aligned edges. Writing only the reference ratio is gentler: the new value is picked up the next time the reference counter wraps on its own. Ratios outside the legal ranges are forced to the nearest legal value. The detector is a two-flag up/down type, and its flags are the block's phase outputs.

Top module: `dual_div_jam`

## Requirements
- R1: While reset is low, and in the first cycle after it rises, `ref_pulse`, `fb_pulse`, `pfd_up` and `pfd_dn` are low. The reference ratio register resets to 5 and the feedback ratio register resets to 40, and each counter starts from its reset ratio.
- R2: With a reference ratio N in 5..32767, `ref_pulse` is high once for every N cycles with `ref_en` high.
- R3: A reference ratio of 1 gives a `ref_pulse` after every cycle with `ref_en` high.
- R4: Reference ratio values 0, 2, 3 and 4 behave exactly as 5.
- R5: With a feedback ratio M in 40..65535, `fb_pulse` is high once for every M cycles with `vco_en` high.
- R6: Feedback ratio values 0..39 behave exactly as 40.
- R7: A cycle with `fb_wr` high loads the feedback counter with the written value and the reference counter with its current ratio. The next pulses come after exactly that many enabled cycles, counted from the following cycle.
- R8: In the cycle after `fb_wr`, `ref_pulse`, `fb_pulse`, `pfd_up` and `pfd_dn` are all low, even if a counter reached terminal count in the write cycle.
- R9: A reference write without a feedback write leaves the running count alone. The new ratio is used from the next natural reload of the reference counter. A reload in the same cycle as the write still uses the old ratio.
- R10: A pulse is high in the clock after an enabled cycle in which the counter stood at 1. With its enable low, a divider neither counts nor pulses.
- R11: A `ref_pulse` sets `pfd_up` one clock later, and an `fb_pulse` sets `pfd_dn` one clock later. A flag stays set until the other pulse arrives. When both flags would be set, both clear, so they are never high together.
- R12: When `ref_wr` and `fb_wr` are high in the same cycle, the jam load uses the newly written reference ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_en | input | 1 | Oscillator count enable for the reference divider |
| vco_en | input | 1 | VCO count enable for the feedback divider |
| ref_wr | input | 1 | Write strobe for the reference ratio register |
| ref_val | input | 15 | Reference ratio value |
| fb_wr | input | 1 | Write strobe for the feedback ratio; also triggers the jam load |
| fb_val | input | 16 | Feedback ratio value |
| ref_pulse | output | 1 | Divided reference pulse |
| fb_pulse | output | 1 | Divided feedback pulse |
| pfd_up | output | 1 | Detector flag: reference leads |
| pfd_dn | output | 1 | Detector flag: feedback leads |

## Verification
The collision that matters most is a feedback write landing in the same cycle in which a counter reaches terminal count with its enable high. There the jam load has to win over the natural reload and the pulse has to be dropped. The bench provokes this by issuing feedback writes at random offsets while both enables are held high, so some writes fall exactly on a wrap of either counter. A second collision is both divider pulses arriving together, which must leave the detector flags clear. Equal ratios with equal enables produce that case. In every case a behavioural model in the bench decides the expected outputs clock by clock.

// File: rtl/pll_div_pkg.sv
// Package: shared constants and types for the jam-loaded divider pair.
// Assumes: consumers size their ports from the width constants below.
package pll_div_pkg;

    localparam int REF_W_DEF   = 15;
    localparam int FB_W_DEF    = 16;
    localparam int REF_MIN_DEF = 5;
    localparam int FB_MIN_DEF  = 40;

    // Detector flag pair.
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

endpackage

// File: rtl/ratio_clamp.sv
// Module: ratio_clamp
// Maps a raw divide ratio to a legal one. Values below MIN_DIV become
// MIN_DIV. When ALLOW_ONE is set, a ratio of exactly 1 is kept as a
// pass-through ratio.
// Assumes: MIN_DIV fits in W bits and is greater than 1.
module ratio_clamp #(
    parameter int W         = 16,
    parameter int MIN_DIV   = 40,
    parameter bit ALLOW_ONE = 1'b0
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] eff_o
);
    localparam logic [W-1:0] MIN_V = W'(MIN_DIV);
    localparam logic [W-1:0] ONE_V = W'(1);

    generate
        if (ALLOW_ONE) begin : g_pass_one
            // Keep 1 as a pass-through ratio, raise other short ratios.
            always_comb begin
                if (raw_i == ONE_V)      eff_o = ONE_V;
                else if (raw_i < MIN_V)  eff_o = MIN_V;
                else                     eff_o = raw_i;
            end
        end else begin : g_floor_only
            // Raise every short ratio to the floor.
            always_comb begin
                if (raw_i < MIN_V) eff_o = MIN_V;
                else               eff_o = raw_i;
            end
        end
    endgenerate

endmodule

// File: rtl/prog_divider.sv
// Module: prog_divider
// Programmable down-counter. It decrements on enabled cycles. At a count
// of 1 on an enabled cycle it raises pulse_o for the next clock and reloads
// from reload_val_i. jam_i overrides all of this: it loads jam_val_i and
// drops any pending pulse.
// Assumes: the value inputs are raw; clamping to legal ratios is done here.
module prog_divider #(
    parameter int W         = 16,
    parameter int MIN_DIV   = 40,
    parameter bit ALLOW_ONE = 1'b0,
    parameter int RST_DIV   = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         jam_i,
    input  logic [W-1:0] jam_val_i,
    input  logic [W-1:0] reload_val_i,
    output logic         pulse_o
);
    localparam logic [W-1:0] ONE_V = W'(1);
    localparam logic [W-1:0] RST_V = W'(RST_DIV);

    logic [W-1:0] cnt;
    logic [W-1:0] jam_eff;
    logic [W-1:0] reload_eff;
    logic [W-1:0] rst_eff;
    logic         at_term;

    ratio_clamp #(.W(W), .MIN_DIV(MIN_DIV), .ALLOW_ONE(ALLOW_ONE)) u_clamp_jam (
        .raw_i (jam_val_i),
        .eff_o (jam_eff)
    );

    ratio_clamp #(.W(W), .MIN_DIV(MIN_DIV), .ALLOW_ONE(ALLOW_ONE)) u_clamp_reload (
        .raw_i (reload_val_i),
        .eff_o (reload_eff)
    );

    ratio_clamp #(.W(W), .MIN_DIV(MIN_DIV), .ALLOW_ONE(ALLOW_ONE)) u_clamp_rst (
        .raw_i (RST_V),
        .eff_o (rst_eff)
    );

    // Terminal count is reached when the counter stands at 1.
    assign at_term = (cnt == ONE_V);

    // Counter: jam load first, then natural reload, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= rst_eff;
        else if (jam_i)           cnt <= jam_eff;
        else if (en_i && at_term) cnt <= reload_eff;
        else if (en_i)            cnt <= cnt - ONE_V;
    end

    // Output pulse: one clock after an enabled terminal cycle, dropped on a jam.
    always_ff @(posedge clk) begin
        if (!rst_n)     pulse_o <= 1'b0;
        else if (jam_i) pulse_o <= 1'b0;
        else            pulse_o <= en_i && at_term;
    end

    // R2
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0);

    // R10
    pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> ($past(en_i) && !$past(jam_i)));

    // R8
    jam_drops_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jam_i |=> !pulse_o);

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !jam_i) |=> $stable(cnt));

endmodule

// File: rtl/phase_freq_det.sv
// Module: phase_freq_det
// Two-flag up/down phase/frequency detector. A reference event sets up, a
// feedback event sets dn, and when both would be set both clear. A
// synchronous clear input empties both flags.
// Assumes: events are single-clock pulses from the dividers.
module phase_freq_det
    import pll_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic ref_evt_i,
    input  logic fb_evt_i,
    output logic up_o,
    output logic dn_o
);
    pfd_flags_t flags;
    pfd_flags_t flags_nx;

    // Next-state: set on events, cancel when both flags are set.
    always_comb begin
        flags_nx.up = flags.up | ref_evt_i;
        flags_nx.dn = flags.dn | fb_evt_i;
        if (flags_nx.up && flags_nx.dn) flags_nx = '0;
    end

    // Flag register with a synchronous clear from the jam load.
    always_ff @(posedge clk) begin
        if (!rst_n)     flags <= '0;
        else if (clr_i) flags <= '0;
        else            flags <= flags_nx;
    end

    assign up_o = flags.up;
    assign dn_o = flags.dn;

    // R11
    pfd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_o && dn_o));

    // R8
    pfd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!up_o && !dn_o));

    // R11
    up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_o) |-> $past(ref_evt_i));

    // R11
    dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dn_o) |-> $past(fb_evt_i));

endmodule

// File: rtl/dual_div_jam.sv
// Module: dual_div_jam (top)
// Holds the two ratio registers. It jam-loads both dividers and clears the
// detector whenever the feedback ratio is written. It feeds the divided
// pulses to the phase/frequency detector.
// Assumes: ref_en and vco_en are single-clock count enables sampled on clk.
module dual_div_jam
    import pll_div_pkg::*;
#(
    parameter int REF_W   = REF_W_DEF,
    parameter int FB_W    = FB_W_DEF,
    parameter int REF_MIN = REF_MIN_DEF,
    parameter int FB_MIN  = FB_MIN_DEF,
    parameter int REF_RST = REF_MIN_DEF,
    parameter int FB_RST  = FB_MIN_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             vco_en,
    input  logic             ref_wr,
    input  logic [REF_W-1:0] ref_val,
    input  logic             fb_wr,
    input  logic [FB_W-1:0]  fb_val,
    output logic             ref_pulse,
    output logic             fb_pulse,
    output logic             pfd_up,
    output logic             pfd_dn
);
    logic [REF_W-1:0] ref_reg;
    logic [FB_W-1:0]  fb_reg;
    logic [REF_W-1:0] ref_jam_val;
    logic             jam;

    // A feedback write is the jam-load strobe.
    assign jam = fb_wr;

    // A reference value written alongside the jam is used by that jam.
    assign ref_jam_val = ref_wr ? ref_val : ref_reg;

    // Reference ratio register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_reg <= REF_W'(REF_RST);
        else if (ref_wr) ref_reg <= ref_val;
    end

    // Feedback ratio register.
    always_ff @(posedge clk) begin
        if (!rst_n)     fb_reg <= FB_W'(FB_RST);
        else if (fb_wr) fb_reg <= fb_val;
    end

    prog_divider #(
        .W(REF_W), .MIN_DIV(REF_MIN), .ALLOW_ONE(1'b1), .RST_DIV(REF_RST)
    ) u_ref_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (ref_en),
        .jam_i        (jam),
        .jam_val_i    (ref_jam_val),
        .reload_val_i (ref_reg),
        .pulse_o      (ref_pulse)
    );

    prog_divider #(
        .W(FB_W), .MIN_DIV(FB_MIN), .ALLOW_ONE(1'b0), .RST_DIV(FB_RST)
    ) u_fb_div (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (vco_en),
        .jam_i        (jam),
        .jam_val_i    (fb_val),
        .reload_val_i (fb_reg),
        .pulse_o      (fb_pulse)
    );

    phase_freq_det u_pfd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (jam),
        .ref_evt_i (ref_pulse),
        .fb_evt_i  (fb_pulse),
        .up_o      (pfd_up),
        .dn_o      (pfd_dn)
    );

    // R8
    jam_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_wr |=> (!ref_pulse && !fb_pulse && !pfd_up && !pfd_dn));

endmodule

// File: tb/tb_dual_div_jam.sv
module tb_dual_div_jam;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0;
    logic        vco_en = 1'b0;
    logic        ref_wr = 1'b0;
    logic [14:0] ref_val = '0;
    logic        fb_wr = 1'b0;
    logic [15:0] fb_val = '0;
    logic        ref_pulse, fb_pulse, pfd_up, pfd_dn;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int p_ref = 100;
    int p_vco = 100;
    bit started = 1'b0;
    string cur_req = "R1";

    // Model state.
    int  m_ref_reg, m_fb_reg, m_rc, m_fc;
    bit  m_rp, m_fp, m_up, m_dn;

    always #2.5 clk = ~clk;

    dual_div_jam dut (
        .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .vco_en(vco_en),
        .ref_wr(ref_wr), .ref_val(ref_val), .fb_wr(fb_wr), .fb_val(fb_val),
        .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .pfd_up(pfd_up), .pfd_dn(pfd_dn)
    );

    function automatic int ref_ratio(int v);
        if (v == 1) return 1;
        if (v < 5) return 5;
        return v;
    endfunction

    function automatic int fb_ratio(int v);
        return (v < 40) ? 40 : v;
    endfunction

    // Behavioural model advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ref_reg = 5; m_fb_reg = 40;
            m_rc = 5; m_fc = 40;
            m_rp = 0; m_fp = 0; m_up = 0; m_dn = 0;
        end else begin
            bit old_rp, old_fp, u, d, nrp, nfp;
            old_rp = m_rp; old_fp = m_fp;
            if (fb_wr) begin
                m_rc = ref_ratio(ref_wr ? int'(ref_val) : m_ref_reg);
                m_fc = fb_ratio(int'(fb_val));
                m_rp = 0; m_fp = 0; m_up = 0; m_dn = 0;
            end else begin
                nrp = ref_en && (m_rc == 1);
                nfp = vco_en && (m_fc == 1);
                if (ref_en) m_rc = (m_rc == 1) ? ref_ratio(m_ref_reg) : m_rc - 1;
                if (vco_en) m_fc = (m_fc == 1) ? fb_ratio(m_fb_reg) : m_fc - 1;
                u = m_up | old_rp;
                d = m_dn | old_fp;
                if (u && d) begin u = 0; d = 0; end
                m_up = u; m_dn = d;
                m_rp = nrp; m_fp = nfp;
            end
            if (ref_wr) m_ref_reg = int'(ref_val);
            if (fb_wr)  m_fb_reg = int'(fb_val);
        end
        started = 1'b1;
    end

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            checks++;
            if ({ref_pulse, fb_pulse, pfd_up, pfd_dn} !== {m_rp, m_fp, m_up, m_dn}) begin
                errors++;
                $display("FAIL %s cycle %0d: got rp=%b fp=%b up=%b dn=%b expected rp=%b fp=%b up=%b dn=%b",
                         cur_req, cycles, ref_pulse, fb_pulse, pfd_up, pfd_dn,
                         m_rp, m_fp, m_up, m_dn);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Run n cycles with random enables at the current probabilities.
    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_wr = 1'b0; fb_wr = 1'b0;
            ref_en = ($urandom_range(99) < p_ref);
            vco_en = ($urandom_range(99) < p_vco);
        end
    endtask

    // One write cycle; enables keep their current values.
    task automatic write(bit wr_r, int rv, bit wr_f, int fv);
        @(negedge clk);
        ref_wr = wr_r; ref_val = 15'(rv);
        fb_wr = wr_f;  fb_val = 16'(fv);
    endtask

    initial begin
        // R1: reset state.
        cur_req = "R1";
        run(4);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({ref_pulse, fb_pulse, pfd_up, pfd_dn} !== 4'b0000) begin
            errors++;
            $display("FAIL R1: got %b expected 0000", {ref_pulse, fb_pulse, pfd_up, pfd_dn});
        end
        run(200);

        // R9: reference write alone waits for the natural reload.
        cur_req = "R9";
        p_ref = 100; p_vco = 100;
        run(3);
        write(1, 7, 0, 0);
        run(120);

        // R7 and R2: jam load with a legal ratio pair.
        cur_req = "R7";
        write(0, 0, 1, 45);
        run(400);
        cur_req = "R2";
        p_ref = 70; p_vco = 60;
        run(600);

        // R3 and R12: ratio 1 written together with a jam.
        cur_req = "R12";
        write(1, 1, 1, 50);
        run(50);
        cur_req = "R3";
        run(300);

        // R4: illegal reference ratios.
        cur_req = "R4";
        write(1, 3, 1, 40);
        run(200);
        write(1, 0, 1, 41);
        run(200);
        write(1, 2, 1, 42);
        run(100);

        // R6: short feedback ratios.
        cur_req = "R6";
        write(1, 6, 1, 10);
        run(300);
        write(0, 0, 1, 0);
        run(300);

        // R8: jams at random offsets, with enables held high.
        cur_req = "R8";
        p_ref = 100; p_vco = 100;
        write(1, 5, 1, 40);
        for (int k = 0; k < 60; k++) begin
            run($urandom_range(45));
            write(0, 0, 1, 40 + $urandom_range(3));
        end
        run(100);

        // R11: equal ratios give simultaneous pulses; then skewed ratios.
        cur_req = "R11";
        write(1, 40, 1, 40);
        run(400);
        write(1, 41, 1, 40);
        run(800);

        // R5: wide ratios with random enables.
        cur_req = "R5";
        p_ref = 80; p_vco = 90;
        write(1, 300, 1, 1000);
        run(6000);
        write(1, 32767, 1, 65535);
        run(2000);

        // R10: enables low, nothing moves.
        cur_req = "R10";
        p_ref = 0; p_vco = 0;
        write(1, 5, 1, 40);
        run(100);
        p_ref = 50; p_vco = 50;
        run(500);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule